// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control and register core of a small accumulator machine. It runs every instruction as a string of subcycles: a fetch, an indirect operand lookup when the instruction asks for one, an execute step, and an interrupt entry when a request is pending. The core reaches its single synchronous memory port only through two registers. An address holding register drives the address lines, and a data holding register both drives the write data and receives read data. A read started in one cycle returns its word in the next cycle.

Instructions are 16-bit words. Load, add and store work on one accumulator. Two jumps, one of them conditional on the zero flag, redirect the program counter. Two more opcodes set and clear the interrupt enable, and a halt opcode stops the machine. An interrupt writes the return address to a fixed memory word and continues at a fixed handler address.

Top module: `instr_cycle_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `memRd` and `memWr` are low, `halted` is low, `accValue` and `statusWord` are zero and the program counter holds `RESET_PC` (default 0x010). The first read after reset is therefore at that address.
- R2: A fetch first copies the program counter into the address register. It then issues a read at that address and adds one to the program counter. The returned word goes into the data register and then into the instruction register.
- R3: The instruction word holds the opcode in bits 15:13, an indirect flag in bit 12 and an address in bits 11:0. The opcodes are 0 load, 1 store, 2 add, 3 jump, 4 jump-if-zero, 5 enable interrupts, 6 disable interrupts and 7 halt.
- R4: When bit 12 is set, one extra read is made at the address field. Bits 11:0 of the word that comes back are then used as the effective address. When bit 12 is clear, the effective address is the address field itself.
- R5: Load reads the word at the effective address into the accumulator and updates only the zero and sign flags. Add puts the two's-complement sum into the accumulator and sets zero, carry, sign and signed overflow.
- R6: Store makes exactly one memory write, of the accumulator value, at the effective address. It leaves the flags unchanged.
- R7: Jump loads the program counter with the effective address. Jump-if-zero does the same only when the zero flag is set, and otherwise the next instruction in sequence runs.
- R8: An interrupt is entered only at the end of an execute step, and only when `irqReq` is high and the enable bit is set. The enable value used is the one after that instruction, so enable and disable take effect at their own boundary. Entry clears the enable bit, copies the program counter into the data register, points the address register at `SAVE_ADDR` (0x000), writes to memory, and then sets the program counter to `HANDLER_ADDR` (0x001).
- R9: Read data is taken from `memRdata` one cycle after `memRd`. `memRd` and `memWr` are never high in the same cycle.
- R10: Halt raises `halted` and keeps it high until reset. After halt, no memory read or write happens and interrupt requests are ignored.
- R11: `statusWord` bits are: bit 0 zero, bit 1 carry, bit 2 sign, bit 3 overflow, bit 4 interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Level-sensitive interrupt request |
| memRdata | input | DATA_W | Read data, valid the cycle after `memRd` |
| memAddr | output | ADDR_W | Memory address (address register) |
| memWdata | output | DATA_W | Write data (data register) |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| halted | output | 1 | High once a halt has executed |
| accValue | output | DATA_W | Accumulator contents |
| statusWord | output | 5 | Flags and interrupt enable, laid out as in R11 |

## Verification
A wrong subcycle state or register transfer shows up at the memory port within a few cycles. It appears as a read at the wrong address, a missing or extra write, or a write carrying the wrong word. Every program ends in stores, so a bad effective address, a wrong flag or a mis-taken branch changes the write stream or the status word sampled with it. A fault in interrupt gating shows up as a missing write, or an extra one, to the save word. A halt that does not hold shows up as memory traffic after `halted` rises.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_JMP   = 3'd3,
    OP_JZ    = 3'd4,
    OP_EI    = 3'd5,
    OP_DI    = 3'd6,
    OP_HALT  = 3'd7
  } opcode_t;

  typedef enum logic [3:0] {
    S_FADDR, S_FRD, S_FCAP, S_FDEC,
    S_IADDR, S_IRD, S_ICAP,
    S_XDISP, S_XRD, S_XCAP, S_XALU, S_XWR,
    S_INT0, S_INT1, S_INT2, S_INT3
  } phase_t;

  typedef struct packed {
    logic marFromPc;
    logic marFromEa;
    logic marSave;
    logic mbrFromMem;
    logic mbrFromPc;
    logic mbrFromAcc;
    logic irLoad;
    logic pcInc;
    logic pcFromEa;
    logic pcHandler;
    logic accLoad;
    logic accAdd;
    logic ieSet;
    logic ieClr;
    logic memRd;
    logic memWr;
  } strobes_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import cyc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 12,
  parameter int RESET_PC     = 'h010,
  parameter int SAVE_ADDR    = 'h000,
  parameter int HANDLER_ADDR = 'h001
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output opcode_t           opcode,
  output logic              indBit,
  output logic              zFlag,
  output logic              ieFlag,
  output logic [DATA_W-1:0] accValue,
  output logic [4:0]        statusWord
);

  localparam int OP_MSB  = DATA_W - 1;
  localparam int IND_POS = DATA_W - 4;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, ir, acc;
  logic              fz, fc, fn, fv, ie;
  logic [DATA_W:0]   sumWide;
  logic [ADDR_W-1:0] effAddr;

  assign effAddr = mbr[ADDR_W-1:0];
  assign sumWide = {1'b0, acc} + {1'b0, mbr};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc  <= ADDR_W'(RESET_PC);
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      fz  <= 1'b0;
      fc  <= 1'b0;
      fn  <= 1'b0;
      fv  <= 1'b0;
      ie  <= 1'b0;
    end else begin
      if (stb.marFromPc)      mar <= pc;
      else if (stb.marFromEa) mar <= effAddr;
      else if (stb.marSave)   mar <= ADDR_W'(SAVE_ADDR);

      if (stb.mbrFromMem)      mbr <= memRdata;
      else if (stb.mbrFromPc)  mbr <= DATA_W'(pc);
      else if (stb.mbrFromAcc) mbr <= acc;

      if (stb.irLoad) ir <= mbr;

      if (stb.pcInc)          pc <= pc + 1'b1;
      else if (stb.pcFromEa)  pc <= effAddr;
      else if (stb.pcHandler) pc <= ADDR_W'(HANDLER_ADDR);

      if (stb.accLoad) begin
        acc <= mbr;
        fz  <= (mbr == '0);
        fn  <= mbr[DATA_W-1];
      end else if (stb.accAdd) begin
        acc <= sumWide[DATA_W-1:0];
        fz  <= (sumWide[DATA_W-1:0] == '0);
        fn  <= sumWide[DATA_W-1];
        fc  <= sumWide[DATA_W];
        fv  <= (acc[DATA_W-1] == mbr[DATA_W-1]) &&
               (sumWide[DATA_W-1] != acc[DATA_W-1]);
      end

      if (stb.ieSet)      ie <= 1'b1;
      else if (stb.ieClr) ie <= 1'b0;
    end
  end

  assign memAddr    = mar;
  assign memWdata   = mbr;
  assign opcode     = opcode_t'(ir[OP_MSB -: 3]);
  assign indBit     = mbr[IND_POS];
  assign zFlag      = fz;
  assign ieFlag     = ie;
  assign accValue   = acc;
  assign statusWord = {ie, fv, fn, fc, fz};

  // R2: each fetch advances the program counter by exactly one
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcInc |=> pc == $past(pc) + 1'b1);

  // R8: interrupt entry leaves the enable bit cleared
  p_ie_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.ieClr |=> !ie);

  // R8: the vector step lands on the handler address
  p_handler_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcHandler |=> pc == ADDR_W'(HANDLER_ADDR));

endmodule

// File: rtl/seq_control.sv
module seq_control
  import cyc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     irqReq,
  input  opcode_t  opcode,
  input  logic     indBit,
  input  logic     zFlag,
  input  logic     ieFlag,
  output strobes_t stb,
  output logic     halted
);

  phase_t state, nxt;
  logic   stopped;
  logic   execDone;
  logic   ieNext;

  // enable value as it stands once the current instruction finishes
  assign ieNext = (state == S_XDISP && opcode == OP_EI) ? 1'b1 :
                  (state == S_XDISP && opcode == OP_DI) ? 1'b0 : ieFlag;

  always_comb begin
    stb      = '0;
    nxt      = state;
    execDone = 1'b0;
    case (state)
      S_FADDR: begin stb.marFromPc = 1'b1; nxt = S_FRD; end
      S_FRD:   begin stb.memRd = 1'b1; stb.pcInc = 1'b1; nxt = S_FCAP; end
      S_FCAP:  begin stb.mbrFromMem = 1'b1; nxt = S_FDEC; end
      S_FDEC:  begin
        stb.irLoad = 1'b1;
        nxt = indBit ? S_IADDR : S_XDISP;
      end
      S_IADDR: begin stb.marFromEa = 1'b1; nxt = S_IRD; end
      S_IRD:   begin stb.memRd = 1'b1; nxt = S_ICAP; end
      S_ICAP:  begin stb.mbrFromMem = 1'b1; nxt = S_XDISP; end
      S_XDISP: begin
        case (opcode)
          OP_LOAD, OP_ADD: begin stb.marFromEa = 1'b1; nxt = S_XRD; end
          OP_STORE: begin
            stb.marFromEa  = 1'b1;
            stb.mbrFromAcc = 1'b1;
            nxt = S_XWR;
          end
          OP_JMP:  begin stb.pcFromEa = 1'b1; execDone = 1'b1; end
          OP_JZ:   begin stb.pcFromEa = zFlag; execDone = 1'b1; end
          OP_EI:   begin stb.ieSet = 1'b1; execDone = 1'b1; end
          OP_DI:   begin stb.ieClr = 1'b1; execDone = 1'b1; end
          default: nxt = S_XDISP;
        endcase
      end
      S_XRD:   begin stb.memRd = 1'b1; nxt = S_XCAP; end
      S_XCAP:  begin stb.mbrFromMem = 1'b1; nxt = S_XALU; end
      S_XALU:  begin
        stb.accLoad = (opcode == OP_LOAD);
        stb.accAdd  = (opcode == OP_ADD);
        execDone    = 1'b1;
      end
      S_XWR:   begin stb.memWr = 1'b1; execDone = 1'b1; end
      S_INT0:  begin stb.mbrFromPc = 1'b1; stb.ieClr = 1'b1; nxt = S_INT1; end
      S_INT1:  begin stb.marSave = 1'b1; nxt = S_INT2; end
      S_INT2:  begin stb.memWr = 1'b1; nxt = S_INT3; end
      S_INT3:  begin stb.pcHandler = 1'b1; nxt = S_FADDR; end
      default: nxt = S_FADDR;
    endcase
    if (execDone) nxt = (irqReq && ieNext) ? S_INT0 : S_FADDR;
    if (stopped) begin
      stb = '0;
      nxt = state;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_FADDR;
      stopped <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_XDISP && opcode == OP_HALT) stopped <= 1'b1;
    end
  end

  assign halted = stopped;

  // R9: the read and write strobes never overlap
  p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.memRd && stb.memWr));

  // R10: once halted, stay halted with the memory port idle
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> stopped && !stb.memRd && !stb.memWr);

  // R8: interrupt entry follows a cycle with the request present
  p_int_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_INT0) |-> $past(irqReq));

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import cyc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 12,
  parameter int RESET_PC     = 'h010,
  parameter int SAVE_ADDR    = 'h000,
  parameter int HANDLER_ADDR = 'h001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRd,
  output logic              memWr,
  output logic              halted,
  output logic [DATA_W-1:0] accValue,
  output logic [4:0]        statusWord
);

  strobes_t stb;
  opcode_t  opcode;
  logic     indBit, zFlag, ieFlag;

  seq_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .irqReq (irqReq),
    .opcode (opcode),
    .indBit (indBit),
    .zFlag  (zFlag),
    .ieFlag (ieFlag),
    .stb    (stb),
    .halted (halted)
  );

  seq_datapath #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .RESET_PC     (RESET_PC),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .opcode     (opcode),
    .indBit     (indBit),
    .zFlag      (zFlag),
    .ieFlag     (ieFlag),
    .accValue   (accValue),
    .statusWord (statusWord)
  );

  assign memRd = stb.memRd;
  assign memWr = stb.memWr;

endmodule

// File: tb/tb_instr_cycle_seq.sv
module tb_instr_cycle_seq;
  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          irqReq = 1'b0;
  logic [DW-1:0] memRdata = '0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memRd, memWr, halted;
  logic [DW-1:0] accValue;
  logic [4:0]    statusWord;

  always #5 clk = ~clk;

  instr_cycle_seq dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memRd(memRd), .memWr(memWr),
    .halted(halted), .accValue(accValue), .statusWord(statusWord)
  );

  logic [DW-1:0] mem [0:255];
  always @(posedge clk) begin
    if (memWr) mem[memAddr[7:0]] <= memWdata;
    if (memRd) memRdata <= mem[memAddr[7:0]];
  end

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [4:0]    s;
  } wr_t;

  wr_t expQ[$];
  int  errors = 0;
  int  checks = 0;
  int  overlap = 0;
  int  haltBusy = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input int op, input bit ind, input int addr);
    return {op[2:0], ind, addr[AW-1:0]};
  endfunction

  task automatic expectWrite(input int a, input int d, input int s);
    wr_t e;
    e.a = a[AW-1:0];
    e.d = d[DW-1:0];
    e.s = s[4:0];
    expQ.push_back(e);
  endtask

  // monitor: pops the scoreboard on every write
  always @(negedge clk) begin
    if (rstN) begin
      if (memRd && memWr) overlap++;
      if (halted && (memRd || memWr)) haltBusy++;
      if (memWr) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected write addr", 32'(memAddr), 32'hFFFF);
        end else begin
          wr_t e;
          e = expQ.pop_front();
          check(memAddr == e.a, "R6", "write address", 32'(memAddr), 32'(e.a));
          check(memWdata == e.d, "R5", "write data", 32'(memWdata), 32'(e.d));
          check(statusWord == e.s, "R11", "status at write", 32'(statusWord), 32'(e.s));
        end
      end
    end
  end

  task automatic startReset();
    rstN = 1'b0;
    irqReq = 1'b0;
    expQ.delete();
    for (int i = 0; i < 256; i++) mem[i] <= '0;
    @(negedge clk);
  endtask

  task automatic releaseAndRun(input string tag);
    int n;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(halted == 1'b1, "R10", {tag, " reached halt"}, 32'(halted), 32'd1);
    repeat (30) @(negedge clk);
    check(expQ.size() == 0, "R6", {tag, " pending writes"}, 32'(expQ.size()), 32'd0);
    check(halted == 1'b1, "R10", {tag, " halt held"}, 32'(halted), 32'd1);
  endtask

  task automatic finish();
    check(overlap == 0, "R9", "rd/wr overlap cycles", 32'(overlap), 32'd0);
    check(haltBusy == 0, "R10", "memory cycles after halt", 32'(haltBusy), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // ---- Program 1: loads, adds, stores, indirect, jumps, flags
    startReset();
    mem[8'h10] <= mk(0, 0, 'h40);   // LOAD 5
    mem[8'h11] <= mk(2, 0, 'h41);   // ADD 7
    mem[8'h12] <= mk(1, 0, 'h50);   // STORE
    mem[8'h13] <= mk(0, 1, 'h42);   // LOAD indirect -> 0x43
    mem[8'h14] <= mk(1, 1, 'h44);   // STORE indirect -> 0x51
    mem[8'h15] <= mk(2, 0, 'h45);   // ADD 0xEDCC -> 0, carry
    mem[8'h16] <= mk(1, 0, 'h52);
    mem[8'h17] <= mk(4, 0, 'h19);   // JZ taken
    mem[8'h18] <= mk(1, 0, 'h53);
    mem[8'h19] <= mk(3, 0, 'h1B);   // JMP
    mem[8'h1A] <= mk(1, 0, 'h53);
    mem[8'h1B] <= mk(0, 0, 'h46);   // LOAD 0x7FFF
    mem[8'h1C] <= mk(2, 0, 'h47);   // ADD 1 -> overflow
    mem[8'h1D] <= mk(1, 0, 'h54);
    mem[8'h1E] <= mk(4, 0, 'h19);   // JZ not taken
    mem[8'h1F] <= mk(7, 0, 0);      // HALT
    mem[8'h40] <= 16'd5;
    mem[8'h41] <= 16'd7;
    mem[8'h42] <= 16'h0043;
    mem[8'h43] <= 16'h1234;
    mem[8'h44] <= 16'h0051;
    mem[8'h45] <= 16'hEDCC;
    mem[8'h46] <= 16'h7FFF;
    mem[8'h47] <= 16'h0001;
    expectWrite('h50, 12, 'h00);
    expectWrite('h51, 'h1234, 'h00);   // R4 indirect load and store
    expectWrite('h52, 0, 'h03);        // R5 zero and carry
    expectWrite('h54, 'h8000, 'h0C);   // R7 jumps skipped 0x53; R5 overflow
    @(negedge clk);
    check(memRd == 1'b0 && memWr == 1'b0, "R1", "strobes in reset", 32'({memRd, memWr}), 32'd0);
    check(halted == 1'b0, "R1", "halted in reset", 32'(halted), 32'd0);
    check(accValue == '0, "R1", "acc in reset", 32'(accValue), 32'd0);
    check(statusWord == '0, "R1", "status in reset", 32'(statusWord), 32'd0);
    rstN = 1'b1;
    while (!memRd) @(negedge clk);
    check(memAddr == AW'('h010), "R2", "first fetch address", 32'(memAddr), 32'h10);
    @(negedge clk);
    while (!memRd) @(negedge clk);
    check(memAddr == AW'('h040), "R3", "load operand address", 32'(memAddr), 32'h40);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    releaseAndRun("P1");
    check(accValue == 16'h8000, "R5", "P1 final acc", 32'(accValue), 32'h8000);
    check(statusWord == 5'h0C, "R11", "P1 final status", 32'(statusWord), 32'h0C);
    irqReq = 1'b1;   // R10: request while halted must do nothing
    repeat (20) @(negedge clk);
    check(memWr == 1'b0 && halted, "R10", "irq ignored when halted", 32'(memWr), 32'd0);

    // ---- Program 2: interrupt entry after enable, request held high
    startReset();
    mem[8'h01] <= mk(1, 0, 'h60);   // handler: STORE
    mem[8'h02] <= mk(7, 0, 0);      // HALT
    mem[8'h10] <= mk(0, 0, 'h40);   // LOAD 0xAA
    mem[8'h11] <= mk(5, 0, 0);      // EI -> interrupt at this boundary
    mem[8'h12] <= mk(0, 0, 'h41);
    mem[8'h13] <= mk(7, 0, 0);
    mem[8'h40] <= 16'h00AA;
    mem[8'h41] <= 16'h00BB;
    expectWrite('h000, 'h0012, 'h00);  // R8 saved PC, enable cleared
    expectWrite('h060, 'h00AA, 'h00);  // R8 handler runs, no re-entry
    irqReq = 1'b1;
    releaseAndRun("P2");
    check(accValue == 16'h00AA, "R8", "P2 acc after handler", 32'(accValue), 32'hAA);
    check(statusWord[4] == 1'b0, "R8", "P2 enable cleared", 32'(statusWord[4]), 32'd0);

    // ---- Program 3: request with enable clear is ignored
    startReset();
    mem[8'h10] <= mk(0, 0, 'h40);
    mem[8'h11] <= mk(1, 0, 'h61);
    mem[8'h12] <= mk(7, 0, 0);
    mem[8'h40] <= 16'h0055;
    expectWrite('h061, 'h0055, 'h00);  // R8 gating: no save write
    irqReq = 1'b1;
    releaseAndRun("P3");
    check(accValue == 16'h0055, "R8", "P3 acc", 32'(accValue), 32'h55);

    finish();
  end

endmodule